// File: doc/BRIEF.md
# Nested Priority Event Controller

This block decides which processor event gets serviced next. It has two stages. A system stage gathers a vector of peripheral request lines. Each line has a programmable assignment that routes it onto one of the core's peripheral interrupt levels. A core stage then weighs those levels against four dedicated event classes: emulation, reset, nonmaskable interrupt and exception. It also weighs two levels that software raises. Every event is identified by a 4-bit index, and a lower index means a higher priority.

Requests are latched as pending on their rising edge. A pending event is taken only when it outranks every handler already running. This lets handlers nest: a more urgent event preempts a running handler, while less urgent ones wait. On a take, the block emits a one-cycle strobe with the event index and records the current program counter in that level's own return-address register. It also marks the level active. A return-from-event pulse retires the most urgent active level. The previous handler's return address then reappears on the output.

Top module: `evt_nest_top`

## Requirements
- R1: Event indices are fixed: emulation 0, reset 1, nonmaskable 2, exception 3, general levels 7 to 15 (indices 4 to 6 are never produced); among several eligible pending events the lowest index is taken first.
- R2: A request is latched as pending on its rising edge and is taken on the second rising clock edge after the request rises, giving `takeEvt` high for exactly one cycle with `evtVec` holding the index; taking clears the pending bit, so a request held high is serviced only once.
- R3: A pending event is taken only if its index is strictly lower than the lowest set bit of `activeMask`; an equal or less urgent event stays pending.
- R4: A `retPulse` clears the lowest set bit of `activeMask` at the next edge, no event is taken on that edge, and a waiting event may be taken on the following edge.
- R5: On a take, `curPc` is stored in the taken level's own return-address register; `retAddr` shows the register of the lowest-index active level, or 0 when no level is active, so a return restores the preempted handler's address.
- R6: A rising edge on either `nmiPin` or `wdogTimeout` raises event index 2.
- R7: Bit j of `maskWrData` (written with `maskWrEn`) enables general level 7+j; all general levels are disabled after reset; a disabled level keeps its pending bit and is taken after it is enabled; indices 0 to 3 ignore the enables.
- R8: Each peripheral line has a 3-bit assignment, written with `mapWrEn`/`mapWrIdx`/`mapWrLvl`; value v in 0..6 routes it to level 7+v, value 7 (the reset value) routes it nowhere; lines routed to the same level are ORed before edge detection.
- R9: `swIrq[0]` raises level 14 and `swIrq[1]` raises level 15.
- R10: After reset `takeEvt` is 0, `activeMask` is 0 and `retAddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| emuReq | input | 1 | Emulation event request |
| rstEvtReq | input | 1 | Reset event request |
| nmiPin | input | 1 | External nonmaskable request |
| wdogTimeout | input | 1 | Watchdog timeout, also raises the nonmaskable event |
| excReq | input | 1 | Synchronous exception request |
| swIrq | input | 2 | Software-raised requests for levels 14 and 15 |
| perReq | input | NPER | Peripheral request lines |
| mapWrEn | input | 1 | Write strobe for one line's level assignment |
| mapWrIdx | input | IW | Line selected for the assignment write |
| mapWrLvl | input | 3 | Assignment value (0..6 level 7+v, 7 none) |
| maskWrEn | input | 1 | Write strobe for the general-level enables |
| maskWrData | input | 9 | Enables for levels 7..15 |
| retPulse | input | 1 | Return-from-event pulse |
| curPc | input | AW | Program counter captured on a take |
| takeEvt | output | 1 | One-cycle take strobe |
| evtVec | output | 4 | Index of the event just taken |
| activeMask | output | 16 | Active handlers, bit per event index |
| retAddr | output | AW | Return address of the most urgent active level |

## Verification
A rising request shows up as `takeEvt` and `evtVec` after exactly two rising edges: one edge latches the pending bit and the next one takes it. The bench therefore drives on a falling edge and samples two falling edges later. A return shows its effect on `activeMask` and `retAddr` after one edge, and any waiting event follows one edge after that. The bench first checks that nothing is taken on the return edge, then samples the new take. A mask write needs one edge before its effect and one more for the take, and the bench waits both before it checks.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int NLVL    = 16;
  localparam int LW      = 4;
  localparam int NGEN    = 9;
  localparam int NPERLVL = 7;

  typedef struct packed {
    logic          take;
    logic [LW-1:0] lvl;
    logic [LW:0]   top;   // LW+1 bits, value NLVL means nothing active
  } ctlStb_t;

  function automatic logic [LW:0] firstSet(input logic [NLVL-1:0] v);
    logic [LW:0] r;
    r = (LW+1)'(NLVL);
    for (int i = NLVL-1; i >= 0; i--)
      if (v[i]) r = (LW+1)'(i);
    return r;
  endfunction
endpackage

// File: rtl/evt_sysmap.sv
module evt_sysmap #(
  parameter int NPER = 8,
  parameter int IW   = (NPER > 1) ? $clog2(NPER) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mapWrEn,
  input  logic [IW-1:0]   mapWrIdx,
  input  logic [2:0]      mapWrLvl,
  input  logic [NPER-1:0] perReq,
  output logic [6:0]      genReq
);
  logic [2:0] asg [NPER];

  for (genvar g = 0; g < NPER; g++) begin : gLine
    always_ff @(posedge clk) begin
      if (!rst_n)                                asg[g] <= 3'd7;
      else if (mapWrEn && mapWrIdx == IW'(g))    asg[g] <= mapWrLvl;
    end
  end

  always_comb begin
    genReq = '0;
    for (int i = 0; i < NPER; i++)
      if (asg[i] != 3'd7) genReq[asg[i]] = genReq[asg[i]] | perReq[i];
  end
endmodule

// File: rtl/evt_ctrl.sv
module evt_ctrl
  import evt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] rawReq,
  input  logic            maskWrEn,
  input  logic [NGEN-1:0] maskWrData,
  input  logic            retPulse,
  output ctlStb_t         stb,
  output logic            takeEvt,
  output logic [LW-1:0]   evtVec,
  output logic [NLVL-1:0] activeMask
);
  logic [NLVL-1:0] prevRaw, pend, riseReq, enMask, elig, clrTake, clrRet;
  logic [NGEN-1:0] genEn;
  logic [LW:0]     winner, topLvl;
  logic            doTake;

  always_comb begin
    riseReq = rawReq & ~prevRaw;
    enMask  = {genEn, 3'b000, 4'b1111};
    elig    = pend & enMask;
    winner  = firstSet(elig);
    topLvl  = firstSet(activeMask);
    doTake  = !retPulse && (winner < topLvl);
    clrTake = doTake ? (NLVL'(1) << winner[LW-1:0]) : '0;
    clrRet  = (retPulse && !topLvl[LW]) ? (NLVL'(1) << topLvl[LW-1:0]) : '0;
    stb.take = doTake;
    stb.lvl  = winner[LW-1:0];
    stb.top  = topLvl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevRaw    <= '0;
      pend       <= '0;
      activeMask <= '0;
      genEn      <= '0;
      takeEvt    <= 1'b0;
      evtVec     <= '0;
    end else begin
      prevRaw    <= rawReq;
      pend       <= (pend & ~clrTake) | riseReq;
      activeMask <= (activeMask & ~clrRet) | clrTake;
      takeEvt    <= doTake;
      if (doTake)   evtVec <= winner[LW-1:0];
      if (maskWrEn) genEn  <= maskWrData;
    end
  end
endmodule

// File: rtl/evt_dpath.sv
module evt_dpath
  import evt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctlStb_t       stb,
  input  logic [AW-1:0] curPc,
  output logic [AW-1:0] retAddr
);
  logic [AW-1:0] saveReg [NLVL];

  for (genvar g = 0; g < NLVL; g++) begin : gSave
    always_ff @(posedge clk) begin
      if (!rst_n)                                 saveReg[g] <= '0;
      else if (stb.take && stb.lvl == LW'(g))     saveReg[g] <= curPc;
    end
  end

  assign retAddr = stb.top[LW] ? '0 : saveReg[stb.top[LW-1:0]];
endmodule

// File: rtl/evt_nest_top.sv
module evt_nest_top
  import evt_pkg::*;
#(
  parameter int NPER = 8,
  parameter int AW   = 32,
  parameter int IW   = (NPER > 1) ? $clog2(NPER) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            emuReq,
  input  logic            rstEvtReq,
  input  logic            nmiPin,
  input  logic            wdogTimeout,
  input  logic            excReq,
  input  logic [1:0]      swIrq,
  input  logic [NPER-1:0] perReq,
  input  logic            mapWrEn,
  input  logic [IW-1:0]   mapWrIdx,
  input  logic [2:0]      mapWrLvl,
  input  logic            maskWrEn,
  input  logic [8:0]      maskWrData,
  input  logic            retPulse,
  input  logic [AW-1:0]   curPc,
  output logic            takeEvt,
  output logic [3:0]      evtVec,
  output logic [15:0]     activeMask,
  output logic [AW-1:0]   retAddr
);
  logic [NPERLVL-1:0] genReq;
  logic [NLVL-1:0]    rawReq;
  ctlStb_t            stb;

  evt_sysmap #(.NPER(NPER), .IW(IW)) uMap (
    .clk(clk), .rst_n(rst_n), .mapWrEn(mapWrEn), .mapWrIdx(mapWrIdx),
    .mapWrLvl(mapWrLvl), .perReq(perReq), .genReq(genReq)
  );

  assign rawReq = {swIrq[1], swIrq[0], genReq, 3'b000, excReq,
                   nmiPin | wdogTimeout, rstEvtReq, emuReq};

  evt_ctrl uCtrl (
    .clk(clk), .rst_n(rst_n), .rawReq(rawReq), .maskWrEn(maskWrEn),
    .maskWrData(maskWrData), .retPulse(retPulse), .stb(stb),
    .takeEvt(takeEvt), .evtVec(evtVec), .activeMask(activeMask)
  );

  evt_dpath #(.AW(AW)) uDp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .curPc(curPc), .retAddr(retAddr)
  );
endmodule

// File: rtl/evt_nest_chk.sv
module evt_nest_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        takeEvt,
  input logic [3:0]  evtVec,
  input logic [15:0] activeMask,
  input logic        retPulse
);
  // R3: a newly taken event is active and outranks every other active level
  assert_take_is_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    takeEvt |-> (activeMask[evtVec] && ((activeMask & ((16'd1 << evtVec) - 16'd1)) == 16'd0)));

  // R1: indices 4 to 6 are never produced
  assert_no_gap_index_R1: assert property (@(posedge clk) disable iff (!rst_n)
    takeEvt |-> (evtVec < 4'd4 || evtVec > 4'd6));

  // R4: a return removes exactly one active level
  assert_ret_pops_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (retPulse && activeMask != 16'd0) |=> ($countones(activeMask) == $countones($past(activeMask)) - 1));

  // R4: nothing is taken on a return edge
  assert_no_take_on_ret_R4: assert property (@(posedge clk) disable iff (!rst_n)
    retPulse |=> !takeEvt);

  // R2: at most one level becomes active per edge
  assert_one_take_per_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(activeMask) <= $countones($past(activeMask)) + 1);
endmodule

bind evt_nest_top evt_nest_chk uChk (
  .clk(clk), .rst_n(rst_n), .takeEvt(takeEvt), .evtVec(evtVec),
  .activeMask(activeMask), .retPulse(retPulse)
);

// File: tb/tb_evt_nest_top.sv
module tb_evt_nest_top;
  localparam int NPER = 8;
  localparam int AW   = 32;
  localparam int IW   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic emuReq = 0, rstEvtReq = 0, nmiPin = 0, wdogTimeout = 0, excReq = 0;
  logic [1:0] swIrq = '0;
  logic [NPER-1:0] perReq = '0;
  logic mapWrEn = 0, maskWrEn = 0, retPulse = 0;
  logic [IW-1:0] mapWrIdx = '0;
  logic [2:0] mapWrLvl = '0;
  logic [8:0] maskWrData = '0;
  logic [AW-1:0] curPc = '0;
  logic takeEvt;
  logic [3:0] evtVec;
  logic [15:0] activeMask;
  logic [AW-1:0] retAddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  evt_nest_top #(.NPER(NPER), .AW(AW), .IW(IW)) dut (
    .clk(clk), .rst_n(rst_n), .emuReq(emuReq), .rstEvtReq(rstEvtReq),
    .nmiPin(nmiPin), .wdogTimeout(wdogTimeout), .excReq(excReq), .swIrq(swIrq),
    .perReq(perReq), .mapWrEn(mapWrEn), .mapWrIdx(mapWrIdx), .mapWrLvl(mapWrLvl),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData), .retPulse(retPulse),
    .curPc(curPc), .takeEvt(takeEvt), .evtVec(evtVec), .activeMask(activeMask),
    .retAddr(retAddr)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic expTake(input string tag, input logic [3:0] vec);
    chk(takeEvt === 1'b1, {tag, " takeEvt"}, 32'(takeEvt), 32'd1);
    chk(evtVec === vec, {tag, " evtVec"}, 32'(evtVec), 32'(vec));
  endtask

  task automatic doRet();
    retPulse = 1; tick(1); retPulse = 0;
  endtask

  task automatic setMask(input logic [8:0] m);
    maskWrData = m; maskWrEn = 1; tick(1); maskWrEn = 0;
  endtask

  task automatic setMap(input int line, input logic [2:0] v);
    mapWrIdx = IW'(line); mapWrLvl = v; mapWrEn = 1; tick(1); mapWrEn = 0;
  endtask

  task automatic tReset();
    chk(takeEvt === 1'b0, "R10 takeEvt", 32'(takeEvt), 0);
    chk(activeMask === 16'h0, "R10 activeMask", 32'(activeMask), 0);
    chk(retAddr === '0, "R10 retAddr", retAddr, 0);
  endtask

  task automatic tNmi();
    curPc = 32'h100;
    wdogTimeout = 1; tick(1); wdogTimeout = 0; tick(1);
    expTake("R6 wdog R2", 4'd2);
    chk(activeMask === 16'h0004, "R2 active after nmi", 32'(activeMask), 32'h4);
    chk(retAddr === 32'h100, "R5 nmi retAddr", retAddr, 32'h100);
    tick(1);
    chk(takeEvt === 1'b0, "R2 single-cycle strobe", 32'(takeEvt), 0);
    doRet();
    chk(activeMask === 16'h0, "R4 ret clears nmi", 32'(activeMask), 0);
    chk(retAddr === '0, "R5 idle retAddr", retAddr, 0);
    nmiPin = 1; tick(1); nmiPin = 0; tick(1);
    expTake("R6 pin", 4'd2);
    doRet();
  endtask

  task automatic tMask();
    setMap(0, 3'd3);                       // line 0 -> level 10
    perReq[0] = 1; tick(1); perReq[0] = 0; tick(2);
    chk(takeEvt === 1'b0 && activeMask === 16'h0, "R7 masked level held", 32'(activeMask), 0);
    setMask(9'h008);                       // enable level 10
    chk(takeEvt === 1'b0, "R7 enable takes one edge", 32'(takeEvt), 0);
    tick(1);
    expTake("R7 pending kept while masked", 4'd10);
    doRet();
    setMask(9'h000);
    excReq = 1; tick(1); excReq = 0; tick(1);
    expTake("R7 exception ignores enables", 4'd3);
    doRet();
  endtask

  task automatic tNest();
    setMap(1, 3'd2);                       // line 1 -> level 9
    setMask(9'h18C);                       // levels 9,10,14,15
    curPc = 32'h200;
    swIrq[1] = 1; tick(1); swIrq[1] = 0; tick(1);
    expTake("R9 level 15", 4'd15);
    chk(retAddr === 32'h200, "R5 level15 addr", retAddr, 32'h200);
    tick(1);
    curPc = 32'h300;
    perReq[1] = 1; tick(1); perReq[1] = 0; tick(1);
    expTake("R3 preempt by 9", 4'd9);
    chk(activeMask === 16'h8200, "R3 nested mask", 32'(activeMask), 32'h8200);
    chk(retAddr === 32'h300, "R5 level9 addr", retAddr, 32'h300);
    tick(1);
    swIrq[0] = 1; tick(1); swIrq[0] = 0; tick(1);
    chk(takeEvt === 1'b0 && activeMask === 16'h8200, "R3 level14 waits", 32'(activeMask), 32'h8200);
    doRet();
    chk(activeMask === 16'h8000, "R4 pop level 9", 32'(activeMask), 32'h8000);
    chk(retAddr === 32'h200, "R5 addr restored", retAddr, 32'h200);
    chk(takeEvt === 1'b0, "R4 no take on ret edge", 32'(takeEvt), 0);
    tick(1);
    expTake("R4 waiting level14 taken", 4'd14);
    doRet();
    chk(retAddr === 32'h200, "R5 back to 15", retAddr, 32'h200);
    swIrq[1] = 1; tick(1); tick(1);
    chk(takeEvt === 1'b0, "R3 equal level not taken", 32'(takeEvt), 0);
    doRet();
    tick(1);
    expTake("R3 equal level after ret", 4'd15);
    doRet(); tick(2);
    chk(takeEvt === 1'b0 && activeMask === 16'h0, "R2 held request once", 32'(activeMask), 0);
    swIrq[1] = 0; tick(1);
  endtask

  task automatic tPriority();
    setMask(9'h004);                       // level 9 only; line 1 still -> 9
    emuReq = 1; rstEvtReq = 1; excReq = 1; perReq[1] = 1;
    tick(1);
    emuReq = 0; rstEvtReq = 0; excReq = 0; perReq[1] = 0;
    tick(1);
    expTake("R1 emulation first", 4'd0);
    doRet(); tick(1);
    expTake("R1 reset second", 4'd1);
    doRet(); tick(1);
    expTake("R1 exception third", 4'd3);
    doRet(); tick(1);
    expTake("R1 level9 last", 4'd9);
    doRet();
    chk(activeMask === 16'h0, "R4 all returned", 32'(activeMask), 0);
  endtask

  task automatic tSysMap();
    setMap(2, 3'd4); setMap(3, 3'd4);      // lines 2,3 -> level 11
    setMask(9'h010);
    perReq[4] = 1; tick(1); perReq[4] = 0; tick(2);
    chk(takeEvt === 1'b0 && activeMask === 16'h0, "R8 unmapped line", 32'(activeMask), 0);
    perReq[3] = 1; tick(1); perReq[3] = 0; tick(1);
    expTake("R8 line3 to 11", 4'd11);
    doRet();
    perReq[2] = 1; tick(1); perReq[2] = 0; tick(1);
    expTake("R8 line2 to 11", 4'd11);
    doRet();
    perReq[2] = 1; tick(2);
    perReq[3] = 1; tick(1); perReq[3] = 0; tick(2);
    chk(takeEvt === 1'b0 && activeMask === 16'h0800, "R8 ORed lines no second edge",
        32'(activeMask), 32'h0800);
    doRet();
    perReq[2] = 0; tick(1);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    tReset();
    tNmi();
    tMask();
    tNest();
    tPriority();
    tSysMap();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog act=%0d exp=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule